// File: doc/BRIEF.md
# Far-End Alarm Code Transmit Sequencer

This block is the transmit-side controller for far-end alarm and control messages in a DS3 framer. Software loads a 6-bit message code into a code register and then writes the go bit in a configuration/status register. At that moment the block captures the code, builds a 16-bit codeword around it and shifts the codeword out serially, LSB first, ten consecutive times. Each serial bit moves forward only when the framer pulses its per-bit request strobe. This strobe stands in for the framer placing the bit into the DS3 overhead.

When the last bit of the tenth codeword has been consumed, the block sets a completion status bit. Reading the configuration/status register clears that bit. The active-low interrupt output is driven low while the status bit is set, but only when both the source-level enable (in the configuration/status register) and the transmit enable in a separate block-level enable register are 1. The block-level register also holds receive and one-second enables, which this block stores and reads back but does not use.

Register access uses a single-cycle write strobe, a read strobe and combinational read data. The register offsets are 0 for the block enable register, 1 for the configuration/status register and 2 for the code register.

Top module: `alarm_tx_seq`

## Requirements
- R1: After reset all three registers read 0, `irq_no` is 1 and `ser_o` is 1.
- R2: The block enable register (offset 0) stores bits 7, 1 and 0 and reads the other bits as 0. Bit 1 is the transmit interrupt enable.
- R3: The configuration/status register (offset 1) reads as {3'b0, irq_en[4], status[3], func_en[2], go[1], busy[0]}. A write with bit 1 and bit 2 both set, made while idle, starts a transmission, and busy reads 1 from the next cycle.
- R4: The codeword is sent LSB first. Bit 0 is 0, bits 1 to 6 are the code LSB first, bit 7 is 0, and bits 8 to 15 are 1. The code is the one captured at the go write; a later write to the code register does not change a transmission already in progress.
- R5: The codeword is sent exactly 10 times. `ser_o` advances one bit per clock with `bit_req_i` high and holds otherwise. Busy clears on the strobe that consumes the 160th bit.
- R6: `ser_o` is 1 while idle or while func_en is 0. Clearing func_en during a transmission aborts it without a completion event.
- R7: A go write while busy, or a go write with func_en 0 in the written data, starts nothing.
- R8: Completion sets the status bit. A read of offset 1 returns the status bit and then clears it. If a completion falls in the same cycle as that read, the status bit stays set.
- R9: `irq_no` is 0 exactly when the status bit, irq_en and block bit 1 are all 1.
- R10: The code register (offset 2) stores 6 bits in bits 5:0, and its bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (clears status on offset 1) |
| addr_i | input | 2 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| bit_req_i | input | 1 | Framer request for the next serial bit |
| ser_o | output | 1 | Serial codeword bit |
| irq_no | output | 1 | Active-low interrupt |

## Verification
A wrong bit index or repetition count shows on `ser_o` at the very strobe where it diverges, because the scoreboard compares every consumed bit against a codeword built independently in the bench. A miscounted repetition also shows as a status bit set too early or too late, or as a busy bit that stays set after the 160th strobe, and this is visible in the first read that follows. Errors in the status or enable state show on `irq_no` one cycle after completion, or immediately after an enable write. The same-cycle read-and-completion case is driven explicitly, so a lost event shows in the next read.

// File: rtl/alarm_tx_pkg.sv
`timescale 1ns/1ps
package alarm_tx_pkg;
  parameter int REG_W   = 8;
  parameter int ADDR_W  = 2;
  parameter int CODE_W  = 6;
  parameter int WORD_W  = 16;
  parameter int REPEATS = 10;

  localparam logic [ADDR_W-1:0] ADR_BLK  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADR_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADR_CODE = ADDR_W'(2);

  // cfg bit positions
  localparam int B_IRQ_EN = 4;
  localparam int B_STS    = 3;
  localparam int B_FN_EN  = 2;
  localparam int B_GO     = 1;
  localparam int B_BUSY   = 0;

  // blk enable bit positions
  localparam int B_RX_EN  = 7;
  localparam int B_TX_EN  = 1;
  localparam int B_SEC_EN = 0;

  // LSB first: 0, code, 0, then ones
  function automatic logic [WORD_W-1:0] make_codeword(input logic [CODE_W-1:0] code);
    logic [WORD_W-1:0] w;
    w = '1;
    w[0] = 1'b0;
    w[CODE_W:1] = code;
    w[CODE_W+1] = 1'b0;
    return w;
  endfunction
endpackage

// File: rtl/alarm_tx_regs.sv
`timescale 1ns/1ps
module alarm_tx_regs
  import alarm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  output logic              start_o,
  output logic              fn_en_o,
  output logic              irq_en_o,
  output logic              sts_o,
  output logic              blk_tx_en_o,
  output logic [CODE_W-1:0] code_o
);
  logic blk_rx_q, blk_tx_q, blk_sec_q;
  logic irq_en_q, sts_q, fn_en_q, go_q;
  logic [CODE_W-1:0] code_q;

  logic wr_blk, wr_cfg, wr_code, rd_cfg;
  assign wr_blk  = wr_en_i && (addr_i == ADR_BLK);
  assign wr_cfg  = wr_en_i && (addr_i == ADR_CFG);
  assign wr_code = wr_en_i && (addr_i == ADR_CODE);
  assign rd_cfg  = rd_en_i && (addr_i == ADR_CFG);

  assign start_o = wr_cfg && wdata_i[B_GO] && wdata_i[B_FN_EN] && !busy_i;

  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_rx_q  <= 1'b0;
      blk_tx_q  <= 1'b0;
      blk_sec_q <= 1'b0;
      irq_en_q  <= 1'b0;
      fn_en_q   <= 1'b0;
      go_q      <= 1'b0;
      code_q    <= '0;
    end else begin
      if (wr_blk) begin
        blk_rx_q  <= wdata_i[B_RX_EN];
        blk_tx_q  <= wdata_i[B_TX_EN];
        blk_sec_q <= wdata_i[B_SEC_EN];
      end
      if (wr_cfg) begin
        irq_en_q <= wdata_i[B_IRQ_EN];
        fn_en_q  <= wdata_i[B_FN_EN];
        go_q     <= wdata_i[B_GO];
      end
      if (wr_code) code_q <= wdata_i[CODE_W-1:0];
    end
  end

  // completion wins over clear-on-read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (done_i) sts_q <= 1'b1;
    else if (rd_cfg) sts_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_BLK: begin
        rdata_o[B_RX_EN]  = blk_rx_q;
        rdata_o[B_TX_EN]  = blk_tx_q;
        rdata_o[B_SEC_EN] = blk_sec_q;
      end
      ADR_CFG: begin
        rdata_o[B_IRQ_EN] = irq_en_q;
        rdata_o[B_STS]    = sts_q;
        rdata_o[B_FN_EN]  = fn_en_q;
        rdata_o[B_GO]     = go_q;
        rdata_o[B_BUSY]   = busy_i;
      end
      ADR_CODE: rdata_o[CODE_W-1:0] = code_q;
      default:  rdata_o = '0;
    endcase
  end

  assign fn_en_o     = fn_en_q;
  assign irq_en_o    = irq_en_q;
  assign sts_o       = sts_q;
  assign blk_tx_en_o = blk_tx_q;
  assign code_o      = code_q;
endmodule

// File: rtl/alarm_tx_shifter.sv
`timescale 1ns/1ps
module alarm_tx_shifter
  import alarm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              fn_en_i,
  input  logic              bit_req_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ser_o,
  output logic [WORD_W-1:0] word_o,
  output logic [$clog2(WORD_W)-1:0] idx_o
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam int REP_W = $clog2(REPEATS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(WORD_W - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPEATS - 1);

  logic              busy_q;
  logic [WORD_W-1:0] word_q;
  logic [IDX_W-1:0]  idx_q;
  logic [REP_W-1:0]  rep_q;
  logic              take;

  assign take   = busy_q && fn_en_i && bit_req_i;
  assign done_o = take && (idx_q == IDX_LAST) && (rep_q == REP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      word_q <= '1;
      idx_q  <= '0;
      rep_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      word_q <= make_codeword(code_i);
      idx_q  <= '0;
      rep_q  <= '0;
    end else if (busy_q && !fn_en_i) begin
      busy_q <= 1'b0;
    end else if (take) begin
      if (idx_q == IDX_LAST) begin
        idx_q <= '0;
        if (rep_q == REP_LAST) busy_q <= 1'b0;
        else                   rep_q  <= rep_q + 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign ser_o  = (busy_q && fn_en_i) ? word_q[idx_q] : 1'b1;
  assign busy_o = busy_q;
  assign word_o = word_q;
  assign idx_o  = idx_q;
endmodule

// File: rtl/alarm_tx_seq.sv
`timescale 1ns/1ps
module alarm_tx_seq
  import alarm_tx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              bit_req_i,
  output logic              ser_o,
  output logic              irq_no
);
  logic start, fn_en, irq_en, sts, blk_tx_en, busy, done;
  logic [CODE_W-1:0] code;
  logic [WORD_W-1:0] word;
  logic [$clog2(WORD_W)-1:0] idx;

  alarm_tx_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .start_o(start), .fn_en_o(fn_en),
    .irq_en_o(irq_en), .sts_o(sts), .blk_tx_en_o(blk_tx_en), .code_o(code)
  );

  alarm_tx_shifter u_shift (
    .clk_i, .rst_ni, .start_i(start), .fn_en_i(fn_en), .bit_req_i,
    .code_i(code), .busy_o(busy), .done_o(done), .ser_o, .word_o(word), .idx_o(idx)
  );

  assign irq_no = !(sts && irq_en && blk_tx_en);
endmodule

// File: rtl/alarm_tx_seq_chk.sv
`timescale 1ns/1ps
module alarm_tx_seq_chk
  import alarm_tx_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              bit_req_i,
  input logic              ser_o,
  input logic              irq_no,
  input logic              busy,
  input logic              done,
  input logic              fn_en,
  input logic              sts,
  input logic              blk_tx_en,
  input logic [WORD_W-1:0] word,
  input logic [$clog2(WORD_W)-1:0] idx
);
  a_r6_idle_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fn_en |-> ser_o);

  a_r5_hold_without_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && fn_en && !bit_req_i && !wr_en_i) |=> $stable(ser_o));

  a_r4_leading_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && fn_en && idx == '0) |-> !ser_o);

  a_r7_word_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !done) |=> $stable(word));

  a_r5_done_clears_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy);

  a_r8_done_sets_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> sts);

  a_r9_block_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !blk_tx_en |-> irq_no);
endmodule

bind alarm_tx_seq alarm_tx_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .bit_req_i(bit_req_i),
  .ser_o(ser_o), .irq_no(irq_no), .busy(busy), .done(done), .fn_en(fn_en),
  .sts(sts), .blk_tx_en(blk_tx_en), .word(word), .idx(idx)
);

// File: tb/alarm_tx_seq_tb.sv
`timescale 1ns/1ps
module alarm_tx_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0, bit_req = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ser, irq_n;

  always #4 clk = ~clk;

  alarm_tx_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .bit_req_i(bit_req), .ser_o(ser), .irq_no(irq_n)
  );

  int   checks = 0, errors = 0;
  logic exp_q[$];
  logic [7:0] d;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic cw_bit(input logic [5:0] c, input int i);
    if (i == 0 || i == 7) return 1'b0;
    if (i >= 1 && i <= 6) return c[i-1];
    return 1'b1;
  endfunction

  task automatic push_code(input logic [5:0] c, input int nbits);
    for (int i = 0; i < nbits; i++) exp_q.push_back(cw_bit(c, i % 16));
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back(1'b1);
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic strobe(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_req = 1'b1;
      if (gap) begin @(negedge clk); bit_req = 1'b0; end
    end
    @(negedge clk); bit_req = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (bit_req) begin
        if (exp_q.size() == 0) chk(1'b0, "R5 strobe with empty queue", ser, 1);
        else begin
          logic e;
          e = exp_q.pop_front();
          chk(ser === e, "R4/R5 serial bit", ser, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    reg_read(2'd0, d); chk(d == 8'h00, "R1 blk reset", d, 0);
    reg_read(2'd1, d); chk(d == 8'h00, "R1 cfg reset", d, 0);
    reg_read(2'd2, d); chk(d == 8'h00, "R1 code reset", d, 0);
    chk(irq_n == 1'b1, "R1 irq reset", irq_n, 1);
    chk(ser == 1'b1, "R1 ser reset", ser, 1);
    // R2
    reg_write(2'd0, 8'hFF); reg_read(2'd0, d); chk(d == 8'h83, "R2 blk mask", d, 8'h83);
    // R10
    reg_write(2'd2, 8'hFF); reg_read(2'd2, d); chk(d == 8'h3F, "R10 code mask", d, 8'h3F);
    reg_write(2'd2, 8'h2D);
    // R3 start, R4 latch, R7 go while busy
    reg_write(2'd1, 8'h16);
    reg_read(2'd1, d); chk(d == 8'h17, "R3 busy after go", d, 8'h17);
    push_code(6'h2D, 160);
    reg_write(2'd2, 8'h12);
    strobe(20, 1'b1);
    reg_write(2'd1, 8'h16);
    strobe(140, 1'b0);
    chk(exp_q.size() == 0, "R5 all bits consumed", exp_q.size(), 0);
    chk(irq_n == 1'b0, "R9 irq asserted", irq_n, 0);
    reg_read(2'd1, d); chk(d == 8'h1E, "R8 status set busy clear", d, 8'h1E);
    reg_read(2'd1, d); chk(d == 8'h16, "R8 cleared on read", d, 8'h16);
    chk(irq_n == 1'b1, "R9 irq released", irq_n, 1);
    // R7 go with function disabled, R6 idle
    reg_write(2'd1, 8'h12);
    reg_read(2'd1, d); chk(d == 8'h12, "R7 go ignored fn off", d, 8'h12);
    push_idle(3); strobe(3, 1'b0);
    // R6 abort
    reg_write(2'd1, 8'h16);
    push_code(6'h12, 5); strobe(5, 1'b0);
    reg_write(2'd1, 8'h10);
    reg_read(2'd1, d); chk(d == 8'h10, "R6 abort no status", d, 8'h10);
    push_idle(4); strobe(4, 1'b0);
    chk(irq_n == 1'b1, "R6 no irq after abort", irq_n, 1);
    // R9 block gating
    reg_write(2'd0, 8'h81);
    reg_write(2'd1, 8'h16);
    push_code(6'h12, 160); strobe(160, 1'b0);
    chk(irq_n == 1'b1, "R9 block mask", irq_n, 1);
    reg_write(2'd0, 8'h83);
    chk(irq_n == 1'b0, "R9 block unmask", irq_n, 0);
    reg_read(2'd1, d); chk(d == 8'h1E, "R8 status under block mask", d, 8'h1E);
    // R9 source gating
    reg_write(2'd1, 8'h06);
    push_code(6'h12, 160); strobe(160, 1'b0);
    chk(irq_n == 1'b1, "R9 source mask", irq_n, 1);
    reg_read(2'd1, d); chk(d == 8'h0E, "R8 status source masked", d, 8'h0E);
    // R8 collision of read and completion
    reg_write(2'd2, 8'h3F);
    reg_write(2'd1, 8'h16);
    push_code(6'h3F, 160); strobe(159, 1'b0);
    @(negedge clk); bit_req = 1'b1; rd_en = 1'b1; addr = 2'd1;
    #1 d = rdata;
    @(negedge clk); bit_req = 1'b0; rd_en = 1'b0;
    chk(d == 8'h17, "R8 read during last bit", d, 8'h17);
    reg_read(2'd1, d); chk(d == 8'h1E, "R8 completion wins", d, 8'h1E);
    reg_read(2'd1, d); chk(d == 8'h16, "R8 later clear", d, 8'h16);
    chk(exp_q.size() == 0, "R5 queue drained", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule